// File: doc/BRIEF.md
# External Bus Strobe Generator

This block generates the two timing strobes of an 8051-style external memory bus from the oscillator clock. A machine cycle is twelve oscillator clocks, counted as phases 0 to 11, which form six states of two clocks each. The address-latch strobe pulses high at the start of state 1 and state 4, so it runs at one sixth of the oscillator rate. While code is fetched from external program memory, the active-low program-store strobe fires twice per machine cycle.

Two request inputs are sampled on the last phase of a machine cycle, and they mark the machine cycle that follows. The external-data request makes that cycle a data-access cycle. In it, the state-1 address-latch pulse and both program-store strobes are dropped. The code-table request marks the cycle as a table-read cycle. A control register holds one bit. When that bit is set, the address-latch driver stays off except in marked cycles, and while the driver is off the pin idles high. External-execution mode overrides this bit.

Top module: `bus_strobe_gen`

## Requirements
- R1: `phase` counts 0,1,...,11 and wraps to 0, advancing once per clock. It is 0 during reset and on the first clock after reset is released.
- R2: In an unmarked cycle with the driver enabled, `ale` is 1 in phases 0 and 6 and 0 in all other phases.
- R3: If `xdata_req` is 1 at a clock edge where `phase` is 11, the next machine cycle is a data cycle. In that cycle `ale` stays 0 in phase 0 and still pulses in phase 6.
- R4: With `ext_exec` at 1, `psen_n` is 0 in phases 2, 3, 8 and 9 of a non-data cycle and 1 in every other phase. With `ext_exec` at 0, `psen_n` is always 1.
- R5: In a data cycle as defined in R3, `psen_n` stays 1 for the whole machine cycle.
- R6: A clocked write with `sfr_we`=1 and `sfr_addr`=8'h8E loads `sfr_wdata[0]` into the disable bit. A write to any other address leaves the bit unchanged. Reset clears the bit.
- R7: With the disable bit at 1 and `ext_exec` at 0, `ale_en` is 1 only in cycles marked by `xdata_req` or `movc_req` (sampled at phase 11). In all other cycles `ale_en` is 0 and `ale` is held at 1.
- R8: With `ext_exec` at 1, the disable bit has no effect: `ale_en` is 1 and `ale` follows R2 and R3.
- R9: While `rst` is 1, `ale` is 0 and `psen_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_exec | input | 1 | Code is executing from external program memory |
| xdata_req | input | 1 | Next machine cycle is an external data access (sampled at phase 11) |
| movc_req | input | 1 | Next machine cycle is a code-table read (sampled at phase 11) |
| sfr_we | input | 1 | Control register write strobe |
| sfr_addr | input | 8 | Control register write address |
| sfr_wdata | input | 8 | Control register write data; bit 0 is the disable bit |
| ale | output | 1 | Address-latch strobe, active high; reads 1 when the driver is off |
| ale_en | output | 1 | Address-latch driver enable |
| psen_n | output | 1 | Program-store strobe, active low |
| phase | output | 4 | Oscillator phase within the machine cycle, 0 to 11 |

## Verification
On every cycle, the assertions check the following properties:
- the phase count steps and wraps correctly;
- `ale` is high only in phases 0 and 6, and is never high in phase 0 of a data cycle (a data cycle is tracked from the ports);
- `psen_n` is low only in its four fetch phases during external execution, and is never low in a data cycle;
- the driver enable holds whenever execution is external.

Some behaviour only the bench's scenarios can show, by comparing against a behavioural model on every clock:
- a write to the wrong address is ignored;
- an enabled driver actually delivers the phase-6 pulse and both fetch strobes;
- the disable bit reopens the driver only in cycles marked as table-read or data cycles.

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen #(
  parameter logic [7:0] CTRL_ADDR = 8'h8E,
  parameter int         PHASES    = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_exec,
  input  logic       xdata_req,
  input  logic       movc_req,
  input  logic       sfr_we,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic       ale,
  output logic       ale_en,
  output logic       psen_n,
  output logic [3:0] phase
);
  localparam logic [3:0] LAST   = 4'(PHASES - 1);
  localparam logic [3:0] S4_PH  = 4'(PHASES / 2);
  localparam logic [3:0] F1_PH  = 4'd2;
  localparam logic [3:0] F2_PH  = 4'(PHASES / 2 + 2);

  logic [3:0] cnt;
  logic       data_cyc, table_cyc, dis_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      data_cyc  <= 1'b0;
      table_cyc <= 1'b0;
      dis_bit   <= 1'b0;
    end else begin
      cnt <= (cnt == LAST) ? '0 : cnt + 4'd1;
      if (cnt == LAST) begin
        data_cyc  <= xdata_req;
        table_cyc <= movc_req;
      end
      if (sfr_we && sfr_addr == CTRL_ADDR)
        dis_bit <= sfr_wdata[0];
    end
  end

  logic gate, pulse, fetch_win;

  assign gate      = !(dis_bit && !ext_exec) || data_cyc || table_cyc;
  assign pulse     = !rst && ((cnt == '0 && !data_cyc) || cnt == S4_PH);
  assign fetch_win = (cnt >> 1) == (F1_PH >> 1) || (cnt >> 1) == (F2_PH >> 1);

  assign ale    = gate ? pulse : 1'b1;
  assign ale_en = gate;
  assign psen_n = !(!rst && ext_exec && !data_cyc && fetch_win);
  assign phase  = cnt;
endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       ext_exec,
  input logic       xdata_req,
  input logic       ale,
  input logic       ale_en,
  input logic       psen_n,
  input logic [3:0] phase
);
  logic in_data;
  always_ff @(posedge clk) begin
    if (rst) in_data <= 1'b0;
    else if (phase == 4'd11) in_data <= xdata_req;
  end

  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    phase == 4'd11 |=> phase == 4'd0);
  p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
    phase != 4'd11 |=> phase == $past(phase) + 4'd1);
  p_ale_slots_r2: assert property (@(posedge clk) disable iff (rst)
    (ale_en && ale) |-> (phase == 4'd0 || phase == 4'd6));
  p_ale_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (in_data && phase == 4'd0) |-> !ale);
  p_psen_window_r4: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> (ext_exec && (phase == 4'd2 || phase == 4'd3 || phase == 4'd8 || phase == 4'd9)));
  p_psen_drop_r5: assert property (@(posedge clk) disable iff (rst)
    in_data |-> psen_n);
  p_idle_high_r7: assert property (@(posedge clk) disable iff (rst)
    !ale_en |-> ale);
  p_override_r8: assert property (@(posedge clk) disable iff (rst)
    ext_exec |-> ale_en);
endmodule

bind bus_strobe_gen bus_strobe_gen_chk u_chk (
  .clk(clk), .rst(rst), .ext_exec(ext_exec), .xdata_req(xdata_req),
  .ale(ale), .ale_en(ale_en), .psen_n(psen_n), .phase(phase)
);

// File: tb/bus_strobe_gen_bench.sv
module bus_strobe_gen_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic ext_exec = 1'b0, xdata_req = 1'b0, movc_req = 1'b0, sfr_we = 1'b0;
  logic [7:0] sfr_addr = '0, sfr_wdata = '0;
  logic ale, ale_en, psen_n;
  logic [3:0] phase;

  bus_strobe_gen u_bus_strobe_gen (
    .clk(clk), .rst(rst), .ext_exec(ext_exec), .xdata_req(xdata_req),
    .movc_req(movc_req), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .ale(ale), .ale_en(ale_en), .psen_n(psen_n),
    .phase(phase)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  string ctx = "R9";
  bit started = 0, done = 0;

  int m_ph = 0;
  bit m_xd = 0, m_mc = 0, m_dis = 0;

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_ph = 0; m_xd = 0; m_mc = 0; m_dis = 0;
    end else begin
      if (m_ph == 11) begin m_xd = xdata_req; m_mc = movc_req; end
      m_ph = (m_ph + 1) % 12;
      if (sfr_we && sfr_addr == 8'h8E) m_dis = sfr_wdata[0];
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", ctx, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      bit open, strobe, fetch;
      int e_ale;
      open   = !(m_dis && !ext_exec) || m_xd || m_mc;
      strobe = !rst && ((m_ph == 0 && !m_xd) || m_ph == 6);
      fetch  = (m_ph inside {2, 3, 8, 9}) && ext_exec && !m_xd && !rst;
      e_ale  = open ? int'(strobe) : 1;
      check("phase", phase, m_ph);
      check("ale", ale, e_ale);
      check("ale_en", ale_en, open);
      check("psen_n", psen_n, !fetch);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    sfr_we = 1; sfr_addr = a; sfr_wdata = d;
    step(1);
    sfr_we = 0;
  endtask

  task automatic cyc(bit xd, bit mc);
    xdata_req = xd; movc_req = mc;
    step(12);
    xdata_req = 0; movc_req = 0;
  endtask

  initial begin
    ctx = "R9"; step(4);
    rst = 0;
    ctx = "R1"; step(1);
    ctx = "R2"; step(35);
    ctx = "R4"; ext_exec = 1; step(36);
    ctx = "R3"; cyc(1, 0); step(12);
    ctx = "R5"; cyc(1, 0); cyc(0, 0); step(12);
    ext_exec = 0;
    ctx = "R6"; wr(8'h8F, 8'h01); step(24);
    wr(8'h8E, 8'h01);
    ctx = "R7"; step(24); cyc(0, 1); cyc(1, 0); cyc(0, 0); step(12);
    ctx = "R8"; ext_exec = 1; step(30); cyc(1, 0); step(12);
    ext_exec = 0;
    ctx = "R6"; wr(8'h8E, 8'h00); step(24);
    ctx = "R9"; rst = 1; step(3); rst = 0; step(6);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule